// File: doc/BRIEF.md
# I2C Master Bus-Event Sequencer

This block is the bus engine of an I2C master. Software-facing logic writes a five-bit command word in which each bit asks for one bus event: a Start condition, a Repeated Start, a Stop condition, reception of one byte, or an acknowledge bit after a received byte. A separate write of a transmit byte, accepted only while the master owns the bus, sends that byte and then samples the slave's answer on the ninth clock.

The engine drives SCL and SDA as open-drain lines: an output enable of 1 pulls a line low, and 0 releases it. It reads both lines back. Every bus event is built from quarter-period steps of `DIV` clock cycles each. A command bit stays set while its event runs and clears by itself when the event ends. A write that arrives while any event runs is dropped, because nothing is queued. One cycle after each completed event, a `done` pulse is raised.

A received byte lands in a read buffer and sets `rx_full`. The acknowledge value that the master sends after a received byte comes from a separate data bit.

Top module: `i2c_evt_master`

## Requirements
- R1: After reset, `cmd_pend`, `ack_data`, `ack_status`, `rx_full` and `busy` are 0, and both line enables are 0, so both lines are released.
- R2: Command bit 0 (Start) is accepted only while the bus is not owned. SDA falls while SCL is high, and then SCL is pulled low. `cmd_pend[0]` reads 1 during the event, `busy` stays high for 3·DIV cycles, and afterwards the bus is owned.
- R3: Command bit 1 (Repeated Start) releases SDA, then SCL, then pulls SDA low while SCL is high, and then pulls SCL low. It produces one start condition and no stop condition, and takes 4·DIV cycles.
- R4: Command bit 2 (Stop) pulls SDA low, releases SCL, and then releases SDA while SCL is high. It takes 3·DIV cycles, leaves both lines released and ends ownership of the bus.
- R5: A transmit-byte write sends the 8 bits MSB first, with SDA changing only while SCL is low. SDA is then released for a ninth clock. The whole transfer takes 36·DIV cycles.
- R6: `ack_status` takes the SDA level sampled on the ninth clock of a transmit: 1 means no acknowledge, 0 means acknowledged. At no other time does it change.
- R7: Command bit 3 (Receive) clocks in 8 bits MSB first with SDA released, in 32·DIV cycles. The byte appears on `rx_data` and sets `rx_full`, and a pulse on `rx_rd` clears `rx_full`.
- R8: Command bit 4 (Acknowledge) sends one clock with SDA at the `ack_data` value captured at launch: 0 pulls SDA low (acknowledge) and 1 releases it (not acknowledge). It takes 4·DIV cycles, and `ack_data` is written through `ack_data_we`.
- R9: Command writes and transmit-byte writes that arrive while `busy` is high are ignored. `cmd_pend` is unchanged and no extra event takes place.
- R10: Stop, Repeated Start, Receive, Acknowledge and transmit writes are refused while the bus is not owned. While the bus is owned and idle, SCL is held low.
- R11: When a write sets several command bits, only the lowest-numbered one is carried out: Start, then Repeated Start, Stop, Receive, Acknowledge. A command write with any bit set takes precedence over a transmit write in the same cycle.
- R12: `done` pulses for exactly one cycle, the cycle in which `busy` falls. A refused write produces neither `busy` nor `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 5 | Command bits: 0 Start, 1 Repeated Start, 2 Stop, 3 Receive, 4 Acknowledge |
| ack_data_we | input | 1 | Write strobe for the acknowledge value |
| ack_data_in | input | 1 | Acknowledge value to store (0 = ACK, 1 = NACK) |
| tx_we | input | 1 | Transmit-byte write strobe |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe that clears rx_full |
| cmd_pend | output | 5 | Command bits still running |
| ack_data | output | 1 | Stored acknowledge value |
| ack_status | output | 1 | Slave answer from the last transmit (1 = no ACK) |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | A received byte is waiting |
| busy | output | 1 | A bus event is running |
| done | output | 1 | One-cycle pulse at the end of an event |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |

## Verification
The assertions assume that nothing outside the master holds SCL low: whenever the engine samples SDA with SCL released, `scl_in` must read high. They also assume that the slave changes SDA only while SCL is low. The bench models the lines as wired-AND with no clock stretching. Its slave model changes its SDA pull only on falling SCL edges, both for the data bits it returns during a receive and for the acknowledge it gives after a transmit. All random stimulus (bytes, acknowledge choices and the `ack_data` value) goes through the normal command and data strobes, so these assumptions hold throughout the run.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  // Operation codes; the first NCMD values equal their command-bit index.
  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RESTART = 3'd1,
    OP_STOP    = 3'd2,
    OP_RX      = 3'd3,
    OP_ACK     = 3'd4,
    OP_TX      = 3'd5
  } op_e;

  localparam int NCMD   = 5;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W + 2);
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run || cnt_q == '0) cnt_d = RELOAD;
    else                     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == '0);

  generate
    if (DIV > 1) begin : g_spacing
      assert_tick_spaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/i2cm_ctl.sv
module i2cm_ctl
  import i2cm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_we,
  input  logic [NCMD-1:0] cmd_wdata,
  input  logic            tx_we,
  input  logic            ack_data_we,
  input  logic            ack_data_in,
  input  logic            busy,
  input  logic            owned,
  input  logic            done,
  output logic            launch,
  output op_e             launch_op,
  output logic [NCMD-1:0] pend,
  output logic            ack_data
);
  logic [NCMD-1:0] pend_q, pend_d;
  logic            ackd_q, ackd_d;
  op_e             sel;
  logic            sel_legal;

  // Lowest-numbered set bit wins.
  always_comb begin
    sel = OP_ACK;
    for (int i = NCMD - 1; i >= 0; i--) begin
      if (cmd_wdata[i]) sel = op_e'(i);
    end
    sel_legal = (sel == OP_START) ? !owned : owned;
  end

  always_comb begin
    launch    = 1'b0;
    launch_op = OP_START;
    if (!busy) begin
      if (cmd_we && (|cmd_wdata)) begin
        launch    = sel_legal;
        launch_op = sel;
      end else if (tx_we && owned) begin
        launch    = 1'b1;
        launch_op = OP_TX;
      end
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (done) pend_d = '0;
    for (int i = 0; i < NCMD; i++) begin
      if (launch && launch_op == op_e'(i)) pend_d[i] = 1'b1;
    end
    ackd_d = ackd_q;
    if (ack_data_we) ackd_d = ack_data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ackd_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ackd_q <= ackd_d;
    end
  end

  assign pend     = pend_q;
  assign ack_data = ackd_q;

  assert_pend_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_q));
  assert_busy_locks_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pend_q));
  assert_done_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !launch) |=> (pend_q == '0));
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              launch,
  input  op_e               launch_op,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              ack_bit,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              busy,
  output logic              done,
  output logic              owned,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_stb,
  output logic              ackst_stb,
  output logic              ackst_val
);
  localparam logic [BIT_W-1:0] TX_LAST  = BIT_W'(BYTE_W);
  localparam logic [BIT_W-1:0] RX_LAST  = BIT_W'(BYTE_W - 1);
  localparam logic [BIT_W-1:0] ACK_LAST = '0;

  logic              busy_q, busy_d, done_q, done_d, own_q, own_d;
  op_e               op_q, op_d;
  logic [1:0]        step_q, step_d;
  logic [BIT_W-1:0]  bit_q, bit_d, last_bit;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              scl_lo_q, scl_lo_d, sda_lo_q, sda_lo_d;
  logic              ackb_q, ackb_d;
  logic              rxs_q, rxs_d, aks_q, aks_d, akv_q, akv_d;
  logic              bit_op, drive_lo, finish;

  assign bit_op = (op_q == OP_TX) || (op_q == OP_RX) || (op_q == OP_ACK);

  always_comb begin
    unique case (op_q)
      OP_TX:   last_bit = TX_LAST;
      OP_RX:   last_bit = RX_LAST;
      default: last_bit = ACK_LAST;
    endcase
    unique case (op_q)
      OP_TX:   drive_lo = (bit_q == TX_LAST) ? 1'b0 : !sh_q[BYTE_W-1];
      OP_ACK:  drive_lo = !ackb_q;
      default: drive_lo = 1'b0;
    endcase
  end

  always_comb begin
    busy_d   = busy_q;
    own_d    = own_q;
    op_d     = op_q;
    step_d   = step_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    scl_lo_d = scl_lo_q;
    sda_lo_d = sda_lo_q;
    ackb_d   = ackb_q;
    akv_d    = akv_q;
    done_d   = 1'b0;
    rxs_d    = 1'b0;
    aks_d    = 1'b0;
    finish   = 1'b0;
    if (launch) begin
      busy_d = 1'b1;
      op_d   = launch_op;
      step_d = '0;
      bit_d  = '0;
      sh_d   = tx_byte;
      ackb_d = ack_bit;
    end else if (busy_q && tick) begin
      step_d = step_q + 2'd1;
      unique case (op_q)
        OP_START: begin
          unique case (step_q)
            2'd0:    begin scl_lo_d = 1'b0; sda_lo_d = 1'b0; end
            2'd1:    sda_lo_d = 1'b1;
            default: begin scl_lo_d = 1'b1; own_d = 1'b1; finish = 1'b1; end
          endcase
        end
        OP_RESTART: begin
          unique case (step_q)
            2'd0:    sda_lo_d = 1'b0;
            2'd1:    scl_lo_d = 1'b0;
            2'd2:    sda_lo_d = 1'b1;
            default: begin scl_lo_d = 1'b1; finish = 1'b1; end
          endcase
        end
        OP_STOP: begin
          unique case (step_q)
            2'd0:    sda_lo_d = 1'b1;
            2'd1:    scl_lo_d = 1'b0;
            default: begin sda_lo_d = 1'b0; own_d = 1'b0; finish = 1'b1; end
          endcase
        end
        default: begin
          unique case (step_q)
            2'd0: sda_lo_d = drive_lo;
            2'd1: scl_lo_d = 1'b0;
            2'd2: begin
              if (op_q == OP_RX) sh_d = {sh_q[BYTE_W-2:0], sda_in};
              if (op_q == OP_TX && bit_q == TX_LAST) begin
                aks_d = 1'b1;
                akv_d = sda_in;
              end
            end
            default: begin
              scl_lo_d = 1'b1;
              if (op_q == OP_TX) sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              bit_d = bit_q + 1'b1;
              if (bit_q == last_bit) begin
                finish = 1'b1;
                rxs_d  = (op_q == OP_RX);
              end
            end
          endcase
        end
      endcase
      if (finish) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      own_q    <= 1'b0;
      op_q     <= OP_START;
      step_q   <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      scl_lo_q <= 1'b0;
      sda_lo_q <= 1'b0;
      ackb_q   <= 1'b0;
      rxs_q    <= 1'b0;
      aks_q    <= 1'b0;
      akv_q    <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      done_q   <= done_d;
      own_q    <= own_d;
      op_q     <= op_d;
      step_q   <= step_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      scl_lo_q <= scl_lo_d;
      sda_lo_q <= sda_lo_d;
      ackb_q   <= ackb_d;
      rxs_q    <= rxs_d;
      aks_q    <= aks_d;
      akv_q    <= akv_d;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign owned     = own_q;
  assign scl_oe    = scl_lo_q;
  assign sda_oe    = sda_lo_q;
  assign rx_byte   = sh_q;
  assign rx_stb    = rxs_q;
  assign ackst_stb = aks_q;
  assign ackst_val = akv_q;

  // SDA never moves while SCL is released during a data or acknowledge bit.
  assert_sda_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bit_op && !scl_lo_q) |=> $stable(sda_lo_q));
  // Environment: with SCL released, the line reads high when sampled.
  assert_scl_high_at_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bit_op && tick && step_q == 2'd2) |-> scl_in);
  assert_start_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && op_q == OP_START) |-> (scl_lo_q && sda_lo_q && own_q));
  assert_stop_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && op_q == OP_STOP) |-> (!scl_lo_q && !sda_lo_q && !own_q));
  assert_owned_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && own_q) |-> scl_lo_q);
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q ##1 !done_q));
endmodule

// File: rtl/i2c_evt_master.sv
module i2c_evt_master
  import i2cm_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [NCMD-1:0]   cmd_wdata,
  input  logic              ack_data_we,
  input  logic              ack_data_in,
  input  logic              tx_we,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic [NCMD-1:0]   cmd_pend,
  output logic              ack_data,
  output logic              ack_status,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full,
  output logic              busy,
  output logic              done,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              scl_in,
  input  logic              sda_in
);
  logic [1:0]        rst_sync_q;
  logic              rst_i;
  logic              tick, launch, owned, rx_stb, ackst_stb, ackst_val;
  op_e               launch_op;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] rxd_q, rxd_d;
  logic              full_q, full_d, acks_q, acks_d;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  i2cm_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_i),
    .run  (busy),
    .tick (tick)
  );

  i2cm_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_i),
    .cmd_we     (cmd_we),
    .cmd_wdata  (cmd_wdata),
    .tx_we      (tx_we),
    .ack_data_we(ack_data_we),
    .ack_data_in(ack_data_in),
    .busy       (busy),
    .owned      (owned),
    .done       (done),
    .launch     (launch),
    .launch_op  (launch_op),
    .pend       (cmd_pend),
    .ack_data   (ack_data)
  );

  i2cm_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_i),
    .tick     (tick),
    .launch   (launch),
    .launch_op(launch_op),
    .tx_byte  (tx_data),
    .ack_bit  (ack_data),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .busy     (busy),
    .done     (done),
    .owned    (owned),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .rx_byte  (rx_byte),
    .rx_stb   (rx_stb),
    .ackst_stb(ackst_stb),
    .ackst_val(ackst_val)
  );

  always_comb begin
    rxd_d  = rxd_q;
    full_d = full_q;
    acks_d = acks_q;
    if (rx_rd) full_d = 1'b0;
    if (rx_stb) begin
      rxd_d  = rx_byte;
      full_d = 1'b1;
    end
    if (ackst_stb) acks_d = ackst_val;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rxd_q  <= '0;
      full_q <= 1'b0;
      acks_q <= 1'b0;
    end else begin
      rxd_q  <= rxd_d;
      full_q <= full_d;
      acks_q <= acks_d;
    end
  end

  assign rx_data    = rxd_q;
  assign rx_full    = full_q;
  assign ack_status = acks_q;

  assert_ackstat_quiet_R6: assert property (@(posedge clk) disable iff (!rst_i)
    !busy |=> $stable(ack_status));
  assert_rx_fill_R7: assert property (@(posedge clk) disable iff (!rst_i)
    rx_stb |=> (rx_full && rx_data == $past(rx_byte)));
endmodule

// File: tb/sim_i2c_evt_master.sv
module sim_i2c_evt_master;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_we, ack_data_we, ack_data_in, tx_we, rx_rd;
  logic [4:0] cmd_wdata;
  logic [7:0] tx_data;
  logic [4:0] cmd_pend;
  logic       ack_data, ack_status, rx_full, busy, done, scl_oe, sda_oe;
  logic [7:0] rx_data;
  logic       scl_in, sda_in, slv_pull;

  int checks = 0;
  int fails  = 0;
  int n_start = 0, n_stop = 0, rise_cnt = 0, fall_cnt = 0;
  int base_r = 0, base_f = 0, slv_mode = 0;
  logic       slv_ack = 1'b0, mon_last = 1'b1;
  logic [7:0] slv_byte = 8'h00, mon_sh = 8'h00, mon_byte = 8'h00;

  always #10 clk = ~clk;

  i2c_evt_master #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .ack_data_we(ack_data_we), .ack_data_in(ack_data_in), .tx_we(tx_we),
    .tx_data(tx_data), .rx_rd(rx_rd), .cmd_pend(cmd_pend), .ack_data(ack_data),
    .ack_status(ack_status), .rx_data(rx_data), .rx_full(rx_full), .busy(busy),
    .done(done), .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in), .sda_in(sda_in)
  );

  // Wired-AND bus with a slave that moves SDA only on SCL falls.
  assign scl_in = ~scl_oe;
  assign sda_in = ~(sda_oe | slv_pull);

  always_comb begin
    int idx;
    idx = fall_cnt - base_f;
    slv_pull = 1'b0;
    if (slv_mode == 1 && idx == 8) slv_pull = slv_ack;
    if (slv_mode == 2 && idx >= 0 && idx < 8) slv_pull = !slv_byte[7 - idx];
  end

  always @(negedge scl_in) fall_cnt <= fall_cnt + 1;
  always @(posedge scl_in) begin
    rise_cnt <= rise_cnt + 1;
    mon_sh   <= {mon_sh[6:0], sda_in};
    mon_last <= sda_in;
    if (rise_cnt - base_r == 7) mon_byte <= {mon_sh[6:0], sda_in};
  end
  always @(negedge sda_in) if (scl_in === 1'b1) n_start <= n_start + 1;
  always @(posedge sda_in) if (scl_in === 1'b1) n_stop  <= n_stop + 1;

  function automatic int exp_cycles(input int steps);
    return steps * DIV;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_cmd(input logic [4:0] b);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = b;
    @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
  endtask

  task automatic pulse_tx(input logic [7:0] b);
    @(negedge clk); tx_we = 1'b1; tx_data = b;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic wait_end(output int cyc, output logic saw_done);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    saw_done = done;
  endtask

  task automatic expect_refused(input string req);
    int seen = 0;
    repeat (4) begin
      if (busy || done) seen++;
      @(negedge clk);
    end
    check(seen == 0, req, "refused write started activity", seen, 0);
  endtask

  task automatic run_cmd(input logic [4:0] b, input logic [4:0] exp_pend,
                         input int steps, input string req);
    int cyc; logic d;
    pulse_cmd(b);
    check(cmd_pend == exp_pend, req, "pending bit during event", cmd_pend, exp_pend);
    wait_end(cyc, d);
    check(cyc == exp_cycles(steps), req, "busy cycles", cyc, exp_cycles(steps));
    check(d == 1'b1, "R12", "done with busy fall", d, 1);
    @(negedge clk);
    check(done == 1'b0 && cmd_pend == 5'd0, "R12", "done single and pend cleared",
          {done, cmd_pend}, 0);
  endtask

  task automatic run_tx(input logic [7:0] b, input logic ack);
    int cyc; logic d;
    slv_mode = 1; slv_ack = ack; base_r = rise_cnt; base_f = fall_cnt;
    pulse_tx(b);
    wait_end(cyc, d);
    check(cyc == exp_cycles(36), "R5", "tx busy cycles", cyc, exp_cycles(36));
    check(mon_byte == b, "R5", "byte on bus MSB first", mon_byte, b);
    check(ack_status == !ack, "R6", "ack status", ack_status, !ack);
    slv_mode = 0;
  endtask

  task automatic run_rx_ack(input logic [7:0] b, input logic ad);
    int cyc; logic d;
    @(negedge clk); ack_data_we = 1'b1; ack_data_in = ad;
    @(negedge clk); ack_data_we = 1'b0;
    check(ack_data == ad, "R8", "ack data stored", ack_data, ad);
    slv_mode = 2; slv_byte = b; base_r = rise_cnt; base_f = fall_cnt;
    pulse_cmd(5'b01000);
    wait_end(cyc, d);
    check(cyc == exp_cycles(32), "R7", "rx busy cycles", cyc, exp_cycles(32));
    @(negedge clk);
    check(rx_full == 1'b1 && rx_data == b, "R7", "rx byte", rx_data, b);
    slv_mode = 0;
    run_cmd(5'b10000, 5'b10000, 4, "R8");
    check(mon_last == ad, "R8", "SDA level on ack clock", mon_last, ad);
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    check(rx_full == 1'b0, "R7", "rx_full cleared by read", rx_full, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int s0, p0, cyc; logic d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmd_we = 0; cmd_wdata = 0; ack_data_we = 0; ack_data_in = 0;
    tx_we = 0; tx_data = 0; rx_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check({cmd_pend, ack_data, ack_status, rx_full, busy, scl_oe, sda_oe} == '0,
          "R1", "reset outputs", {cmd_pend, ack_data, ack_status, rx_full, busy}, 0);

    // R10 refusals while bus is free
    pulse_tx(8'hA5);            expect_refused("R10");
    pulse_cmd(5'b00100);        expect_refused("R10");
    pulse_cmd(5'b01000);        expect_refused("R10");

    // R2 start
    s0 = n_start;
    run_cmd(5'b00001, 5'b00001, 3, "R2");
    check(n_start == s0 + 1 && scl_oe && sda_oe, "R2", "start condition and lines",
          n_start - s0, 1);
    pulse_cmd(5'b00001);        expect_refused("R10");
    check(scl_oe == 1'b1, "R10", "SCL held low while owned", scl_oe, 1);

    // R5/R6 directed corners then random
    run_tx(8'h00, 1'b1);
    run_tx(8'hFF, 1'b0);
    for (int i = 0; i < 6; i++) run_tx(8'($urandom), 1'($urandom));

    // R9 writes during a running receive
    p0 = n_stop;
    slv_mode = 2; slv_byte = 8'h3C; base_r = rise_cnt; base_f = fall_cnt;
    pulse_cmd(5'b01000);
    repeat (5) @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = 5'b00100; tx_we = 1'b1; tx_data = 8'h55;
    @(negedge clk); cmd_we = 1'b0; cmd_wdata = 0; tx_we = 1'b0;
    check(cmd_pend == 5'b01000, "R9", "pend unchanged by busy write", cmd_pend, 5'b01000);
    wait_end(cyc, d);
    check(cyc == exp_cycles(32) - 6, "R9", "remaining busy cycles", cyc, exp_cycles(32) - 6);
    repeat (2) @(negedge clk);
    check(!busy && n_stop == p0 && rx_data == 8'h3C, "R9", "no extra event",
          n_stop - p0, 0);
    slv_mode = 0;
    @(negedge clk); rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;

    // R7/R8 receive then acknowledge
    run_rx_ack(8'hC3, 1'b0);
    run_rx_ack(8'h81, 1'b1);
    for (int i = 0; i < 3; i++) run_rx_ack(8'($urandom), 1'($urandom));

    // R3 repeated start
    s0 = n_start; p0 = n_stop;
    run_cmd(5'b00010, 5'b00010, 4, "R3");
    check(n_start == s0 + 1 && n_stop == p0, "R3", "one start and no stop",
          n_start - s0, 1);

    // R11 priority: stop+rx+ack -> stop only; R4 stop
    p0 = n_stop;
    run_cmd(5'b11100, 5'b00100, 3, "R11");
    check(n_stop == p0 + 1 && !scl_oe && !sda_oe, "R4", "stop and lines released",
          n_stop - p0, 1);
    pulse_tx(8'h11);            expect_refused("R10");

    // R11 start beats others when free; command beats tx
    s0 = n_start;
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = 5'b10111; tx_we = 1'b1; tx_data = 8'h77;
    @(negedge clk); cmd_we = 1'b0; cmd_wdata = 0; tx_we = 1'b0;
    check(cmd_pend == 5'b00001, "R11", "start chosen", cmd_pend, 5'b00001);
    wait_end(cyc, d);
    check(cyc == exp_cycles(3) && n_start == s0 + 1, "R11", "start length", cyc, exp_cycles(3));
    run_cmd(5'b00100, 5'b00100, 3, "R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule